// File: doc/BRIEF.md
# Current-Aware Discontinuous PWM Clamp Selector

This block runs once per modulation sampling period in a multilevel inverter controller. It decides which of the three output phases is held at a carrier band edge for the whole period, so that the phase carrying the largest load current does not switch. Its inputs are three signed load-current samples and the three nominal modulating signals, each already reduced to its active carrier band, together with the indices of the phases holding the largest and smallest signal. Its outputs are the extra zero-sequence offset to add to all three nominal signals, the index of the phase that this offset clamps, and a code for the rule that produced the choice.

The block finds the clamp target by ranking the current magnitudes directly, so it needs no current-vector angle or rotation. If the strongest-current phase can be pinned to the top or bottom of the band, that phase is chosen. Otherwise the phase with the middle current is tried. When neither phase can be pinned, the offset with the smaller magnitude is used. Nominal signals are unsigned fixed point with `FRAC_W` fractional bits, so the band edge 1.0 is `2**FRAC_W`. Phase indices are a=0, b=1, c=2.

Top module: `dpwm_clamp_sel`

## Requirements
- R1: Phases are ranked by the absolute value of their current. When two magnitudes are equal, the lower phase index (a=0, b=1, c=2) ranks higher. The top-ranked phase is the primary target and the second-ranked phase is the secondary target.
- R2: If the primary target is the phase named by `max_sel`, the offset is ONE minus that phase's signal, `clamp_phase` is that phase, and `rule` is 2'b01. This holds even when `min_sel` names the same phase.
- R3: If the primary target is not the `max_sel` phase but is the `min_sel` phase, the offset is the negative of its signal, `clamp_phase` is that phase, and `rule` is 2'b01.
- R4: If the primary target is neither phase, the secondary target is tested the same way (high clamp preferred, then low clamp), and `rule` is 2'b10.
- R5: If neither target is the `max_sel` or `min_sel` phase, `rule` is 2'b11. The offset is ONE minus the max signal and `clamp_phase` is `max_sel` when that value is strictly smaller than the min signal. Otherwise the offset is the negative of the min signal and `clamp_phase` is `min_sel`.
- R6: The offset always lies within [-min signal, ONE - max signal], with both edges reachable. The clamped phase's signal plus the offset equals exactly 0 or ONE.
- R7: Every sample taken with `in_valid` high produces a result with `out_valid` high exactly two clock edges later. Samples on consecutive cycles give results on consecutive cycles.
- R8: While `rst` is high, `out_valid`, `offset`, `clamp_phase` and `rule` are cleared to zero on the clock edge.
- R9: In cycles where `out_valid` is low, `offset`, `clamp_phase` and `rule` keep the values of the last result.
- R10: The most negative current code, -2**(CUR_W-1), ranks above the most positive code, 2**(CUR_W-1)-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe for all other inputs |
| cur_a | input | CUR_W | Phase a load current, two's complement |
| cur_b | input | CUR_W | Phase b load current, two's complement |
| cur_c | input | CUR_W | Phase c load current, two's complement |
| sig_a | input | FRAC_W+1 | Phase a nominal signal, 0..ONE |
| sig_b | input | FRAC_W+1 | Phase b nominal signal, 0..ONE |
| sig_c | input | FRAC_W+1 | Phase c nominal signal, 0..ONE |
| max_sel | input | 2 | Index of phase with the largest signal |
| min_sel | input | 2 | Index of phase with the smallest signal |
| out_valid | output | 1 | Result strobe |
| offset | output | FRAC_W+2 | Signed offset to add to every nominal signal |
| clamp_phase | output | 2 | Index of the phase that stops switching |
| rule | output | 2 | 01 primary, 10 secondary, 11 fallback |

## Verification
Tie-breaking in the current ranking and selection of the fallback rule can both affect the same sample. A case that provokes both drives three equal current magnitudes together with a degenerate signal ranking, where one phase is both `max_sel` and `min_sel` and that phase is neither the primary nor the secondary target. If the ranking breaks the tie wrongly, the degenerate phase becomes a target and the result reports rule 01 or 10 instead of the fallback. The result is judged by the expected offset, phase and rule code. Separate cases cover a magnitude tie with distinct targets and the extreme negative current code, so that a fault in ranking shows up as a different clamp phase.

// File: rtl/dpwm_clamp_pkg.sv
package dpwm_clamp_pkg;
  localparam int NPH   = 3;
  localparam int IDX_W = 2;

  typedef logic [IDX_W-1:0] phase_t;

  typedef enum logic [1:0] {
    RULE_NONE     = 2'b00,
    RULE_PRIMARY  = 2'b01,
    RULE_SECOND   = 2'b10,
    RULE_FALLBACK = 2'b11
  } rule_e;
endpackage

// File: rtl/dpwm_cur_rank.sv
module dpwm_cur_rank
  import dpwm_clamp_pkg::*;
#(
  parameter int CUR_W = 12
) (
  input  logic [NPH*CUR_W-1:0] cur_flat,
  output phase_t               first_idx,
  output phase_t               second_idx
);
  logic [CUR_W-1:0] mag   [NPH];
  phase_t           place [NPH];

  generate
    for (genvar p = 0; p < NPH; p++) begin : g_mag
      logic signed [CUR_W-1:0] raw;
      assign raw    = cur_flat[p*CUR_W +: CUR_W];
      assign mag[p] = raw[CUR_W-1] ? (~raw + 1'b1) : raw;
    end
  endgenerate

  // place = number of phases that outrank this one (ties go to lower index)
  always_comb begin
    for (int p = 0; p < NPH; p++) begin
      place[p] = '0;
      for (int q = 0; q < NPH; q++) begin
        if (q != p && ((mag[q] > mag[p]) || (mag[q] == mag[p] && q < p)))
          place[p] = place[p] + 1'b1;
      end
    end
  end

  always_comb begin
    first_idx  = '0;
    second_idx = '0;
    for (int p = 0; p < NPH; p++) begin
      if (place[p] == phase_t'(0)) first_idx  = phase_t'(p);
      if (place[p] == phase_t'(1)) second_idx = phase_t'(p);
    end
  end
endmodule

// File: rtl/dpwm_clamp_pick.sv
module dpwm_clamp_pick
  import dpwm_clamp_pkg::*;
#(
  parameter int FRAC_W = 8
) (
  input  logic [NPH*(FRAC_W+1)-1:0] sig_flat,
  input  phase_t                    max_sel,
  input  phase_t                    min_sel,
  input  phase_t                    first_idx,
  input  phase_t                    second_idx,
  output logic signed [FRAC_W+1:0]  offset,
  output phase_t                    clamp_phase,
  output rule_e                     rule
);
  localparam int SIG_W = FRAC_W + 1;
  localparam int OFF_W = FRAC_W + 2;
  localparam logic [OFF_W-1:0] ONE = OFF_W'(1) << FRAC_W;

  logic [SIG_W-1:0]        sig [NPH];
  logic [SIG_W-1:0]        sig_max, sig_min;
  logic signed [OFF_W-1:0] hi_off, lo_off;

  generate
    for (genvar p = 0; p < NPH; p++) begin : g_sig
      assign sig[p] = sig_flat[p*SIG_W +: SIG_W];
    end
  endgenerate

  always_comb begin
    sig_max = '0;
    sig_min = '0;
    for (int p = 0; p < NPH; p++) begin
      if (max_sel == phase_t'(p)) sig_max = sig[p];
      if (min_sel == phase_t'(p)) sig_min = sig[p];
    end
  end

  assign hi_off = $signed(ONE - {1'b0, sig_max});
  assign lo_off = -$signed({1'b0, sig_min});

  always_comb begin
    if (first_idx == max_sel) begin
      offset = hi_off; clamp_phase = first_idx;  rule = RULE_PRIMARY;
    end else if (first_idx == min_sel) begin
      offset = lo_off; clamp_phase = first_idx;  rule = RULE_PRIMARY;
    end else if (second_idx == max_sel) begin
      offset = hi_off; clamp_phase = second_idx; rule = RULE_SECOND;
    end else if (second_idx == min_sel) begin
      offset = lo_off; clamp_phase = second_idx; rule = RULE_SECOND;
    end else if (hi_off < $signed({1'b0, sig_min})) begin
      offset = hi_off; clamp_phase = max_sel;    rule = RULE_FALLBACK;
    end else begin
      offset = lo_off; clamp_phase = min_sel;    rule = RULE_FALLBACK;
    end
  end
endmodule

// File: rtl/dpwm_clamp_sel.sv
module dpwm_clamp_sel
  import dpwm_clamp_pkg::*;
#(
  parameter int CUR_W  = 12,
  parameter int FRAC_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [CUR_W-1:0]  cur_a,
  input  logic signed [CUR_W-1:0]  cur_b,
  input  logic signed [CUR_W-1:0]  cur_c,
  input  logic [FRAC_W:0]          sig_a,
  input  logic [FRAC_W:0]          sig_b,
  input  logic [FRAC_W:0]          sig_c,
  input  logic [1:0]               max_sel,
  input  logic [1:0]               min_sel,
  output logic                     out_valid,
  output logic signed [FRAC_W+1:0] offset,
  output logic [1:0]               clamp_phase,
  output logic [1:0]               rule
);
  localparam int SIG_W = FRAC_W + 1;
  localparam int OFF_W = FRAC_W + 2;

  // stage 1: magnitude ranking
  phase_t                   rank_first, rank_second;
  logic                     s1_valid;
  phase_t                   s1_first, s1_second, s1_max, s1_min;
  logic [NPH*SIG_W-1:0]     s1_sig;

  dpwm_cur_rank #(.CUR_W(CUR_W)) u_rank (
    .cur_flat  ({cur_c, cur_b, cur_a}),
    .first_idx (rank_first),
    .second_idx(rank_second)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      s1_first  <= '0;
      s1_second <= '0;
      s1_max    <= '0;
      s1_min    <= '0;
      s1_sig    <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_first  <= rank_first;
        s1_second <= rank_second;
        s1_max    <= max_sel;
        s1_min    <= min_sel;
        s1_sig    <= {sig_c, sig_b, sig_a};
      end
    end
  end

  // stage 2: clamp decision
  logic signed [OFF_W-1:0] pick_off;
  phase_t                  pick_phase;
  rule_e                   pick_rule;

  dpwm_clamp_pick #(.FRAC_W(FRAC_W)) u_pick (
    .sig_flat   (s1_sig),
    .max_sel    (s1_max),
    .min_sel    (s1_min),
    .first_idx  (s1_first),
    .second_idx (s1_second),
    .offset     (pick_off),
    .clamp_phase(pick_phase),
    .rule       (pick_rule)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      offset      <= '0;
      clamp_phase <= '0;
      rule        <= RULE_NONE;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        offset      <= pick_off;
        clamp_phase <= pick_phase;
        rule        <= pick_rule;
      end
    end
  end
endmodule

// File: rtl/dpwm_clamp_chk.sv
module dpwm_clamp_chk #(
  parameter int CUR_W  = 12,
  parameter int FRAC_W = 8
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     in_valid,
  input logic signed [CUR_W-1:0]  cur_a,
  input logic signed [CUR_W-1:0]  cur_b,
  input logic signed [CUR_W-1:0]  cur_c,
  input logic [FRAC_W:0]          sig_a,
  input logic [FRAC_W:0]          sig_b,
  input logic [FRAC_W:0]          sig_c,
  input logic [1:0]               max_sel,
  input logic [1:0]               min_sel,
  input logic                     out_valid,
  input logic signed [FRAC_W+1:0] offset,
  input logic [1:0]               clamp_phase,
  input logic [1:0]               rule
);
  localparam int SIG_W = FRAC_W + 1;
  localparam int W     = FRAC_W + 3;
  localparam logic signed [W-1:0] ONE = W'(1) << FRAC_W;

  logic [1:0]           age;
  logic [3*SIG_W-1:0]   sig_d1, sig_d2;
  logic [1:0]           mx_d1, mx_d2, mn_d1, mn_d2;

  always_ff @(posedge clk) begin
    if (rst) age <= '0;
    else if (age != 2'd2) age <= age + 2'd1;
    sig_d1 <= {sig_c, sig_b, sig_a};
    sig_d2 <= sig_d1;
    mx_d1  <= max_sel;
    mx_d2  <= mx_d1;
    mn_d1  <= min_sel;
    mn_d2  <= mn_d1;
  end

  function automatic logic signed [W-1:0] pick(input logic [3*SIG_W-1:0] v, input logic [1:0] i);
    case (i)
      2'd0:    pick = W'(v[0 +: SIG_W]);
      2'd1:    pick = W'(v[SIG_W +: SIG_W]);
      default: pick = W'(v[2*SIG_W +: SIG_W]);
    endcase
  endfunction

  logic signed [W-1:0] off_x, mod_clamped, mod_max, mod_min;
  assign off_x       = W'(offset);
  assign mod_clamped = pick(sig_d2, clamp_phase) + off_x;
  assign mod_max     = pick(sig_d2, mx_d2) + off_x;
  assign mod_min     = pick(sig_d2, mn_d2) + off_x;

  a_r7_two_cycle_latency: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2) |-> (out_valid == $past(in_valid, 2)));

  a_r6_clamped_at_edge: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2 && out_valid) |-> (mod_clamped == '0 || mod_clamped == ONE));

  a_r6_inside_band: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2 && out_valid) |-> (mod_max <= ONE && mod_min >= '0));

  a_r5_rule_code_legal: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (rule != 2'b00 && clamp_phase != 2'd3));

  a_r8_reset_clear: assert property (@(posedge clk)
    rst |=> (!out_valid && rule == 2'b00 && offset == '0 && clamp_phase == 2'd0));

  a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2 && !out_valid) |-> ($stable(offset) && $stable(clamp_phase) && $stable(rule)));
endmodule

bind dpwm_clamp_sel dpwm_clamp_chk #(.CUR_W(CUR_W), .FRAC_W(FRAC_W)) u_chk (.*);

// File: tb/dpwm_clamp_sel_test.sv
module dpwm_clamp_sel_test;
  localparam int CUR_W  = 12;
  localparam int FRAC_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [CUR_W-1:0] cur_a = '0, cur_b = '0, cur_c = '0;
  logic [FRAC_W:0] sig_a = '0, sig_b = '0, sig_c = '0;
  logic [1:0] max_sel = '0, min_sel = '0;
  logic out_valid;
  logic signed [FRAC_W+1:0] offset;
  logic [1:0] clamp_phase, rule;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  dpwm_clamp_sel #(.CUR_W(CUR_W), .FRAC_W(FRAC_W)) uut (.*);

  task automatic check(input int act, input int exp, input string tag);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drive(input int ia, ib, ic, xa, xb, xc, mx, mn);
    cur_a = CUR_W'(ia); cur_b = CUR_W'(ib); cur_c = CUR_W'(ic);
    sig_a = (FRAC_W+1)'(xa); sig_b = (FRAC_W+1)'(xb); sig_c = (FRAC_W+1)'(xc);
    max_sel = 2'(mx); min_sel = 2'(mn);
    in_valid = 1'b1;
  endtask

  task automatic expect_out(input int eo, ei, er, input string tag);
    check(int'(out_valid), 1, {tag, " valid"});
    check(int'(offset), eo, {tag, " offset"});
    check(int'(clamp_phase), ei, {tag, " phase"});
    check(int'(rule), er, {tag, " rule"});
  endtask

  task automatic run_case(input int ia, ib, ic, xa, xb, xc, mx, mn, eo, ei, er, input string tag);
    @(negedge clk); drive(ia, ib, ic, xa, xb, xc, mx, mn);
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk); expect_out(eo, ei, er, tag);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(int'(out_valid), 0, "R8 reset valid");
    check(int'(offset), 0, "R8 reset offset");
    check(int'(rule), 0, "R8 reset rule");
  endtask

  task automatic t_back_to_back();
    @(negedge clk); drive(500, -200, -300, 200, 50, 120, 0, 1);
    @(negedge clk); drive(100, -900, 800, 30, 10, 250, 2, 1);
    @(negedge clk); in_valid = 1'b0; expect_out(56, 0, 1, "R7 first of pair");
    @(negedge clk); expect_out(-10, 1, 1, "R7 second of pair");
  endtask

  task automatic t_hold();
    repeat (3) @(negedge clk);
    check(int'(out_valid), 0, "R9 idle valid");
    check(int'(offset), -10, "R9 hold offset");
    check(int'(clamp_phase), 1, "R9 hold phase");
    check(int'(rule), 1, "R9 hold rule");
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    run_case(500, -200, -300, 200, 50, 120, 0, 1, 56, 0, 1, "R2 primary high");
    run_case(1000, 3, -5, 77, 77, 77, 0, 0, 179, 0, 1, "R2 high preferred");
    run_case(100, -900, 800, 30, 10, 250, 2, 1, -10, 1, 1, "R3 primary low");
    run_case(700, -600, -100, 128, 40, 200, 2, 1, -40, 1, 2, "R4 secondary low");
    run_case(-300, 300, 0, 100, 200, 150, 1, 0, -100, 0, 1, "R1 tie to phase a");
    run_case(-2048, 2047, 0, 60, 230, 100, 1, 0, -60, 0, 1, "R10 extreme negative");
    run_case(900, 500, 10, 100, 100, 100, 2, 2, -100, 2, 3, "R5 fallback low");
    run_case(900, 500, 10, 220, 220, 220, 2, 2, 36, 2, 3, "R5 fallback high");
    run_case(50, -50, 50, 100, 100, 100, 2, 2, -100, 2, 3, "R1 R5 tie with fallback");
    run_case(1000, 1, 2, 256, 0, 10, 0, 1, 0, 0, 1, "R6 top edge");
    run_case(5, 1000, 3, 100, 0, 256, 2, 1, 0, 1, 1, "R6 bottom edge");
    t_back_to_back();
    t_hold();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); t_reset();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule